// File: doc/BRIEF.md
# Write-Once Snooping Cache Coherence Controller

This block keeps one small direct-mapped cache coherent with its peers on a shared snooping bus. Every line carries one of four coherence states: invalid, valid (clean, possibly shared), reserved (clean, exclusively held after a single write that also went through to memory) and dirty (modified, held only here). The processor side takes single-word read and write requests. It reports hit or miss in the first cycle of a request and holds a stall until the request has completed.

On the bus side the controller asks for the bus with a request/grant pair, then drives one transaction at a time until the bus acknowledges completion. There are four transaction kinds: a plain read, a write-through that also invalidates other copies, a read-invalidate, and a write-back of a dirty victim. The controller also watches the transactions of other caches. It answers in the same cycle that their address is valid: it drives a memory-inhibit line and supplies its data when it holds the requested word dirty, and it updates the line state at the next clock edge.

Each line is one data word. The address splits into a low index field that selects the line and an upper tag field.

Top module: `coh_wo_ctrl`

## Requirements
- R1: After reset every line is invalid, `bus_req`, `bus_valid` and `snp_inhibit` are low, and the first access to any index reports a miss.
- R2: A read whose tag matches a line in state valid, reserved or dirty completes in its first cycle with no stall and no bus transaction, and returns the stored word on `cpu_rdata`.
- R3: A read miss issues one bus-read (`bus_cmd` = 1) at the requested address. The line takes `bus_rdata`, enters the valid state, and the word is returned to the processor.
- R4: A write that hits a valid line issues one write-through-invalidate (`bus_cmd` = 2) that carries the new word, and leaves the line reserved, so the next write to it is local.
- R5: A write that hits a reserved or dirty line completes in its first cycle with no bus transaction, stores the word and leaves the line dirty.
- R6: A write miss issues one read-invalidate (`bus_cmd` = 3) at the requested address. The line then holds the processor's word in the dirty state.
- R7: On a miss whose victim line is dirty, a write-back (`bus_cmd` = 4) of the victim's address and word comes first, followed by the fill. Victims that are valid, reserved or invalid are dropped with no write-back.
- R8: A snooped bus-read (`snp_cmd` = 1) that hits a dirty line asserts `snp_inhibit` and drives the line's word on `snp_data` in the same cycle, and the line becomes valid. A hit on a reserved line asserts no inhibit, and that line also becomes valid.
- R9: A snooped write-through-invalidate (2) or read-invalidate (3) that hits a local line makes it invalid. A read-invalidate that hits a dirty line also asserts `snp_inhibit` and supplies the word.
- R10: A snoop whose tag differs from the stored tag, a snoop of an invalid line, and a snooped write-back (4) raise no inhibit and leave the line state unchanged.
- R11: A request that needs the bus stalls through one request cycle, one arbitration cycle and one transfer cycle for each transaction. `bus_req` stays high from arbitration to completion, and `bus_cmd`, `bus_addr` and `bus_wdata` hold steady until `bus_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until it completes |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Word address: index in the low IDX_W bits, tag above |
| cpu_wdata | input | DW | Write word |
| cpu_rdata | output | DW | Read word, valid when the request completes |
| cpu_hit | output | 1 | Tag match on a non-invalid line in the first request cycle |
| cpu_miss | output | 1 | No usable line in the first request cycle |
| cpu_stall | output | 1 | Request cannot complete this cycle |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| bus_valid | output | 1 | Own transaction on the bus |
| bus_cmd | output | 3 | 0 none, 1 read, 2 write-through-invalidate, 3 read-invalidate, 4 write-back |
| bus_addr | output | AW | Transaction address |
| bus_wdata | output | DW | Word for write-through or write-back |
| bus_rdata | input | DW | Word returned to a bus-read |
| bus_done | input | 1 | Own transaction completes at this edge |
| snp_valid | input | 1 | Another master's transaction is visible |
| snp_cmd | input | 3 | Snooped command, same encoding as `bus_cmd` |
| snp_addr | input | AW | Snooped address |
| snp_inhibit | output | 1 | Keep memory from answering; this cache supplies the word |
| snp_data | output | DW | Supplied word, zero when not inhibiting |

## Verification
A wrong line state stays hidden until the next access to that index, so the bench exposes it through the very next operation. A line left valid instead of reserved produces a second write-through where none is allowed. A dirty line wrongly cleaned fails to inhibit on the next snooped read. A line not invalidated by a snoop returns a stale hit instead of a bus-read. Every state reached in a per-index walk is therefore probed at once, within two or three cycles, by a read, a write or a snoop whose bus command, inhibit and stall count reveal the state.

// File: rtl/coh_pkg.sv
package coh_pkg;

  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_VAL = 2'd1,
    LS_RSV = 2'd2,
    LS_DRT = 2'd3
  } line_st_e;

  typedef enum logic [2:0] {
    BC_NONE  = 3'd0,
    BC_READ  = 3'd1,
    BC_WTINV = 3'd2,
    BC_RDINV = 3'd3,
    BC_WBACK = 3'd4
  } bus_cmd_e;

  // A write may complete without the bus only on an exclusively held line.
  function automatic logic write_stays_local(line_st_e s);
    return (s == LS_RSV) || (s == LS_DRT);
  endfunction

  // State reached by a matching line after another master's transaction.
  function automatic line_st_e snoop_next(line_st_e s, bus_cmd_e c);
    line_st_e n;
    n = s;
    if (s != LS_INV) begin
      case (c)
        BC_READ:            n = LS_VAL;
        BC_WTINV, BC_RDINV: n = LS_INV;
        default:            n = s;
      endcase
    end
    return n;
  endfunction

  // Only a dirty owner answers instead of memory.
  function automatic logic snoop_supplies(line_st_e s, bus_cmd_e c);
    return (s == LS_DRT) && ((c == BC_READ) || (c == BC_RDINV));
  endfunction

  // State of the local line once its own transaction completes.
  function automatic line_st_e fill_state(bus_cmd_e c);
    line_st_e n;
    case (c)
      BC_READ:  n = LS_VAL;
      BC_WTINV: n = LS_RSV;
      BC_RDINV: n = LS_DRT;
      default:  n = LS_INV;
    endcase
    return n;
  endfunction

  // Transaction needed for a pending request, decided when the grant arrives.
  function automatic bus_cmd_e pick_cmd(logic tag_hit, logic is_wr, line_st_e s);
    bus_cmd_e c;
    if (tag_hit)          c = (is_wr && (s == LS_VAL)) ? BC_WTINV : BC_NONE;
    else if (s == LS_DRT) c = BC_WBACK;
    else                  c = is_wr ? BC_RDINV : BC_READ;
    return c;
  endfunction

endpackage

// File: rtl/coh_line_store.sv
module coh_line_store
  import coh_pkg::*;
#(
  parameter int IDX_W = 2,
  parameter int TAG_W = 6,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] a_idx,
  output line_st_e         a_st,
  output logic [TAG_W-1:0] a_tag,
  output logic [DW-1:0]    a_data,
  input  logic [IDX_W-1:0] b_idx,
  output line_st_e         b_st,
  output logic [TAG_W-1:0] b_tag,
  output logic [DW-1:0]    b_data,
  input  logic             own_we,
  input  logic [IDX_W-1:0] own_idx,
  input  line_st_e         own_st,
  input  logic [TAG_W-1:0] own_tag,
  input  logic             own_data_we,
  input  logic [DW-1:0]    own_data,
  input  logic             snp_we,
  input  logic [IDX_W-1:0] snp_idx,
  input  line_st_e         snp_st
);
  localparam int LINES = 1 << IDX_W;

  line_st_e         st_arr   [LINES];
  logic [TAG_W-1:0] tag_arr  [LINES];
  logic [DW-1:0]    data_arr [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    line_st_e         st_q;
    logic [TAG_W-1:0] tag_q;
    logic [DW-1:0]    data_q;
    logic             own_sel;
    logic             snp_sel;

    assign own_sel = own_we && (own_idx == IDX_W'(g));
    assign snp_sel = snp_we && (snp_idx == IDX_W'(g));

    // The local transaction wins; the bus never carries both at once.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q   <= LS_INV;
        tag_q  <= '0;
        data_q <= '0;
      end else if (own_sel) begin
        st_q  <= own_st;
        tag_q <= own_tag;
        if (own_data_we) data_q <= own_data;
      end else if (snp_sel) begin
        st_q <= snp_st;
      end
    end

    assign st_arr[g]   = st_q;
    assign tag_arr[g]  = tag_q;
    assign data_arr[g] = data_q;
  end

  assign a_st   = st_arr[a_idx];
  assign a_tag  = tag_arr[a_idx];
  assign a_data = data_arr[a_idx];
  assign b_st   = st_arr[b_idx];
  assign b_tag  = tag_arr[b_idx];
  assign b_data = data_arr[b_idx];

endmodule

// File: rtl/coh_snoop_unit.sv
module coh_snoop_unit
  import coh_pkg::*;
#(
  parameter int AW    = 8,
  parameter int IDX_W = 2,
  parameter int DW    = 8,
  parameter int TAG_W = AW - IDX_W
) (
  input  logic             snp_valid,
  input  logic [2:0]       snp_cmd,
  input  logic [AW-1:0]    snp_addr,
  input  line_st_e         line_st,
  input  logic [TAG_W-1:0] line_tag,
  input  logic [DW-1:0]    line_data,
  output logic [IDX_W-1:0] look_idx,
  output logic             snp_match,
  output logic             snp_inhibit,
  output logic [DW-1:0]    snp_data,
  output logic             upd_we,
  output line_st_e         upd_st
);
  bus_cmd_e seen_cmd;

  assign seen_cmd    = bus_cmd_e'(snp_cmd);
  assign look_idx    = snp_addr[IDX_W-1:0];
  assign snp_match   = snp_valid && (line_st != LS_INV) && (line_tag == snp_addr[AW-1:IDX_W]);
  assign snp_inhibit = snp_match && snoop_supplies(line_st, seen_cmd);
  assign snp_data    = snp_inhibit ? line_data : '0;
  assign upd_st      = snoop_next(line_st, seen_cmd);
  assign upd_we      = snp_match && (upd_st != line_st);

endmodule

// File: rtl/coh_cpu_fsm.sv
module coh_cpu_fsm
  import coh_pkg::*;
#(
  parameter int AW    = 8,
  parameter int IDX_W = 2,
  parameter int DW    = 8,
  parameter int TAG_W = AW - IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_req,
  input  logic             cpu_we,
  input  logic [AW-1:0]    cpu_addr,
  input  logic [DW-1:0]    cpu_wdata,
  output logic [DW-1:0]    cpu_rdata,
  output logic             cpu_hit,
  output logic             cpu_miss,
  output logic             cpu_stall,
  input  line_st_e         line_st,
  input  logic [TAG_W-1:0] line_tag,
  input  logic [DW-1:0]    line_data,
  output logic [IDX_W-1:0] look_idx,
  output logic             bus_req,
  input  logic             bus_gnt,
  output logic             bus_valid,
  output bus_cmd_e         bus_cmd,
  output logic [AW-1:0]    bus_addr,
  output logic [DW-1:0]    bus_wdata,
  input  logic [DW-1:0]    bus_rdata,
  input  logic             bus_done,
  output logic             own_we,
  output logic [IDX_W-1:0] own_idx,
  output line_st_e         own_st,
  output logic [TAG_W-1:0] own_tag,
  output logic             own_data_we,
  output logic [DW-1:0]    own_data,
  output logic             local_wr,
  output logic             xfer_end
);
  typedef enum logic [1:0] {F_IDLE, F_ARB, F_XFER, F_RESP} fsm_e;

  fsm_e             fsm_q, fsm_d;
  bus_cmd_e         cmd_q, cmd_sel;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wdata_q;
  logic [TAG_W-1:0] req_tag;
  logic             tag_hit, local_ok, in_idle, grant_go;

  assign look_idx = cpu_addr[IDX_W-1:0];
  assign req_tag  = cpu_addr[AW-1:IDX_W];
  assign tag_hit  = (line_st != LS_INV) && (line_tag == req_tag);
  assign local_ok = tag_hit && (!cpu_we || write_stays_local(line_st));
  assign in_idle  = (fsm_q == F_IDLE);
  assign cmd_sel  = pick_cmd(tag_hit, cpu_we, line_st);
  assign grant_go = (fsm_q == F_ARB) && cpu_req && bus_gnt && (cmd_sel != BC_NONE);
  assign local_wr = cpu_req && in_idle && cpu_we && local_ok;
  assign xfer_end = (fsm_q == F_XFER) && bus_done;

  always_comb begin
    fsm_d = fsm_q;
    case (fsm_q)
      F_IDLE: if (cpu_req && !local_ok) fsm_d = F_ARB;
      F_ARB: begin
        if (!cpu_req)                           fsm_d = F_IDLE;
        else if (bus_gnt && cmd_sel == BC_NONE) fsm_d = F_IDLE;
        else if (grant_go)                      fsm_d = F_XFER;
      end
      F_XFER: if (bus_done) fsm_d = (cmd_q == BC_WBACK) ? F_ARB : F_RESP;
      default: fsm_d = F_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsm_q   <= F_IDLE;
      cmd_q   <= BC_NONE;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      fsm_q <= fsm_d;
      if (grant_go) begin
        cmd_q   <= cmd_sel;
        addr_q  <= (cmd_sel == BC_WBACK) ? {line_tag, look_idx} : cpu_addr;
        wdata_q <= (cmd_sel == BC_WBACK) ? line_data : cpu_wdata;
      end
    end
  end

  assign cpu_hit   = cpu_req && in_idle && tag_hit;
  assign cpu_miss  = cpu_req && in_idle && !tag_hit;
  assign cpu_stall = cpu_req && !((in_idle && local_ok) || (fsm_q == F_RESP));
  assign cpu_rdata = line_data;

  assign bus_req   = (fsm_q == F_ARB) || (fsm_q == F_XFER);
  assign bus_valid = (fsm_q == F_XFER);
  assign bus_cmd   = bus_valid ? cmd_q : BC_NONE;
  assign bus_addr  = addr_q;
  assign bus_wdata = wdata_q;

  assign own_we      = local_wr || xfer_end;
  assign own_idx     = look_idx;
  assign own_st      = local_wr ? LS_DRT : fill_state(cmd_q);
  assign own_tag     = req_tag;
  assign own_data_we = local_wr || (xfer_end && (cmd_q != BC_WBACK));
  assign own_data    = (xfer_end && (cmd_q == BC_READ)) ? bus_rdata : cpu_wdata;

endmodule

// File: rtl/coh_wo_ctrl.sv
module coh_wo_ctrl
  import coh_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 8,
  parameter int IDX_W = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          cpu_hit,
  output logic          cpu_miss,
  output logic          cpu_stall,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic          bus_valid,
  output logic [2:0]    bus_cmd,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_done,
  input  logic          snp_valid,
  input  logic [2:0]    snp_cmd,
  input  logic [AW-1:0] snp_addr,
  output logic          snp_inhibit,
  output logic [DW-1:0] snp_data
);
  localparam int TAG_W = AW - IDX_W;

  line_st_e         cpu_line_st, snp_line_st, own_st, snp_upd_st;
  logic [TAG_W-1:0] cpu_line_tag, snp_line_tag, own_tag;
  logic [DW-1:0]    cpu_line_data, snp_line_data, own_data;
  logic [IDX_W-1:0] cpu_idx, snp_idx, own_idx;
  logic             own_we, own_data_we, snp_upd_we, snp_match;
  logic             local_wr, xfer_end;
  bus_cmd_e         fsm_cmd;

  coh_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DW(DW)) store_i (
    .clk(clk), .rst_n(rst_n),
    .a_idx(cpu_idx), .a_st(cpu_line_st), .a_tag(cpu_line_tag), .a_data(cpu_line_data),
    .b_idx(snp_idx), .b_st(snp_line_st), .b_tag(snp_line_tag), .b_data(snp_line_data),
    .own_we(own_we), .own_idx(own_idx), .own_st(own_st), .own_tag(own_tag),
    .own_data_we(own_data_we), .own_data(own_data),
    .snp_we(snp_upd_we), .snp_idx(snp_idx), .snp_st(snp_upd_st)
  );

  coh_snoop_unit #(.AW(AW), .IDX_W(IDX_W), .DW(DW)) snoop_i (
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .line_st(snp_line_st), .line_tag(snp_line_tag), .line_data(snp_line_data),
    .look_idx(snp_idx), .snp_match(snp_match), .snp_inhibit(snp_inhibit),
    .snp_data(snp_data), .upd_we(snp_upd_we), .upd_st(snp_upd_st)
  );

  coh_cpu_fsm #(.AW(AW), .IDX_W(IDX_W), .DW(DW)) fsm_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_hit(cpu_hit), .cpu_miss(cpu_miss), .cpu_stall(cpu_stall),
    .line_st(cpu_line_st), .line_tag(cpu_line_tag), .line_data(cpu_line_data),
    .look_idx(cpu_idx),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_valid(bus_valid), .bus_cmd(fsm_cmd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_done(bus_done),
    .own_we(own_we), .own_idx(own_idx), .own_st(own_st), .own_tag(own_tag),
    .own_data_we(own_data_we), .own_data(own_data),
    .local_wr(local_wr), .xfer_end(xfer_end)
  );

  assign bus_cmd = fsm_cmd;

endmodule

// File: rtl/coh_wo_chk.sv
module coh_wo_chk #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_we,
  input logic          cpu_hit,
  input logic          cpu_stall,
  input logic          bus_req,
  input logic          bus_valid,
  input logic          bus_done,
  input logic [2:0]    bus_cmd,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          snp_valid,
  input logic [2:0]    snp_cmd,
  input logic          snp_inhibit,
  input logic [1:0]    cur_st,
  input logic          local_wr,
  input logic          xfer_end
);
  assert_idle_bus_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> bus_req);

  assert_read_hit_fast_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_hit && !cpu_we) |-> !cpu_stall);

  assert_fill_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_end && bus_cmd == 3'd1) |=> (cur_st == 2'd1));

  assert_wt_reserved_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_end && bus_cmd == 3'd2) |=> (cur_st == 2'd2));

  assert_local_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    local_wr |-> (!cpu_stall && !bus_valid));

  assert_rdinv_dirty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_end && bus_cmd == 3'd3) |=> (cur_st == 2'd3));

  assert_wb_victim_dirty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_cmd == 3'd4) |-> (cur_st == 2'd3));

  assert_wb_leaves_inv_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_end && bus_cmd == 3'd4) |=> (cur_st == 2'd0));

  assert_inhibit_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    snp_inhibit |-> (snp_valid && (snp_cmd == 3'd1 || snp_cmd == 3'd3)));

  assert_no_inhibit_wb_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_cmd == 3'd4) |-> !snp_inhibit);

  assert_xfer_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_done) |=> (bus_valid && $stable(bus_cmd) && $stable(bus_addr) && $stable(bus_wdata)));

endmodule

bind coh_wo_ctrl coh_wo_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_hit(cpu_hit), .cpu_stall(cpu_stall),
  .bus_req(bus_req), .bus_valid(bus_valid), .bus_done(bus_done), .bus_cmd(bus_cmd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .snp_valid(snp_valid), .snp_cmd(snp_cmd),
  .snp_inhibit(snp_inhibit), .cur_st(cpu_line_st), .local_wr(local_wr), .xfer_end(xfer_end)
);

// File: tb/coh_wo_ctrl_tb_top.sv
`timescale 1ns/1ps
module coh_wo_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_req = 1'b0, cpu_we = 1'b0;
  logic [7:0] cpu_addr = '0, cpu_wdata = '0, cpu_rdata;
  logic       cpu_hit, cpu_miss, cpu_stall;
  logic       bus_req, bus_gnt = 1'b0, bus_valid, bus_done = 1'b0;
  logic [2:0] bus_cmd;
  logic [7:0] bus_addr, bus_wdata, bus_rdata = '0;
  logic       snp_valid = 1'b0;
  logic [2:0] snp_cmd = '0;
  logic [7:0] snp_addr = '0, snp_data;
  logic       snp_inhibit;

  int         n_chk = 0, n_bad = 0;
  logic [7:0] mem [256];
  logic [2:0] lg_cmd [4];
  logic [7:0] lg_addr [4], lg_data [4];
  int         lg_n, stall_n;
  logic       hit0;
  logic [7:0] rd;

  always #4 clk = ~clk;

  coh_wo_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_hit(cpu_hit), .cpu_miss(cpu_miss),
    .cpu_stall(cpu_stall), .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_valid(bus_valid),
    .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_done(bus_done), .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .snp_inhibit(snp_inhibit), .snp_data(snp_data)
  );

  function automatic logic [7:0] init_word(logic [7:0] a);
    return 8'(a * 5 + 3);
  endfunction

  function automatic logic [7:0] dv(int i, int k);
    return 8'(128 + i * 16 + k);
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // One processor request; plays arbiter, memory and bus acknowledge.
  task automatic cpu_op(input logic we, input logic [7:0] a, input logic [7:0] d);
    bit first;
    first = 1'b1;
    lg_n = 0;
    stall_n = 0;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    forever begin
      #1;
      if (first) begin hit0 = cpu_hit; first = 1'b0; end
      if (!cpu_stall) begin rd = cpu_rdata; break; end
      stall_n++;
      bus_gnt  = bus_req && !bus_valid;
      bus_done = bus_valid;
      if (bus_valid) begin
        if (lg_n < 4) begin
          lg_cmd[lg_n] = bus_cmd; lg_addr[lg_n] = bus_addr; lg_data[lg_n] = bus_wdata;
        end
        lg_n++;
        bus_rdata = mem[bus_addr];
        if (bus_cmd == 3'd2 || bus_cmd == 3'd4) mem[bus_addr] = bus_wdata;
      end
      @(negedge clk);
    end
    @(negedge clk);
    cpu_req = 1'b0; bus_gnt = 1'b0; bus_done = 1'b0;
  endtask

  task automatic snoop(input logic [2:0] c, input logic [7:0] a, input logic exp_inh,
                       input logic [7:0] exp_d, input string r);
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = c; snp_addr = a;
    #1;
    chk({r, " inhibit"}, 32'(snp_inhibit), 32'(exp_inh));
    if (exp_inh) chk({r, " supplied word"}, 32'(snp_data), 32'(exp_d));
    @(negedge clk);
    snp_valid = 1'b0; snp_cmd = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish");
    summary();
  end

  initial begin
    for (int k = 0; k < 256; k++) mem[k] = init_word(8'(k));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 bus_req after reset", 32'(bus_req), 0);
    chk("R1 bus_valid after reset", 32'(bus_valid), 0);
    chk("R1 stall without request", 32'(cpu_stall), 0);
    snoop(3'd1, 8'h05, 1'b0, 8'h00, "R1 snoop on reset line");

    for (int i = 0; i < 4; i++) begin
      logic [7:0] a, b, c, e;
      a = {6'(i + 1),  2'(i)};
      b = {6'(i + 9),  2'(i)};
      c = {6'(i + 17), 2'(i)};
      e = {6'(i + 25), 2'(i)};

      cpu_op(1'b0, a, 8'h00);
      chk("R1 first access misses", 32'(hit0), 0);
      chk("R3 one bus op", lg_n, 1);
      chk("R3 bus-read cmd", 32'(lg_cmd[0]), 1);
      chk("R3 bus-read addr", 32'(lg_addr[0]), 32'(a));
      chk("R3 fill word", 32'(rd), 32'(init_word(a)));
      chk("R11 stall cycles single op", stall_n, 3);

      cpu_op(1'b0, a, 8'h00);
      chk("R2 read hit flag", 32'(hit0), 1);
      chk("R2 no bus on hit", lg_n, 0);
      chk("R2 no stall on hit", stall_n, 0);
      chk("R2 hit word", 32'(rd), 32'(init_word(a)));

      cpu_op(1'b1, a, dv(i, 1));
      chk("R4 write hit flag", 32'(hit0), 1);
      chk("R4 one bus op", lg_n, 1);
      chk("R4 write-through cmd", 32'(lg_cmd[0]), 2);
      chk("R4 write-through addr", 32'(lg_addr[0]), 32'(a));
      chk("R4 write-through word", 32'(lg_data[0]), 32'(dv(i, 1)));

      cpu_op(1'b1, a, dv(i, 2));
      chk("R5 write on reserved local", lg_n, 0);
      chk("R5 write on reserved no stall", stall_n, 0);
      cpu_op(1'b0, a, 8'h00);
      chk("R5 stored word", 32'(rd), 32'(dv(i, 2)));
      cpu_op(1'b1, a, dv(i, 3));
      chk("R5 write on dirty local", lg_n, 0);

      snoop(3'd1, a, 1'b1, dv(i, 3), "R8 snoop read on dirty");
      snoop(3'd1, a, 1'b0, 8'h00, "R8 dirty became valid");
      cpu_op(1'b1, a, dv(i, 4));
      chk("R8 line valid after supply (write-through seen)", 32'(lg_cmd[0]), 2);

      snoop(3'd1, a, 1'b0, 8'h00, "R8 snoop read on reserved");
      cpu_op(1'b1, a, dv(i, 4));
      chk("R8 reserved became valid (write-through again)", 32'(lg_cmd[0]), 2);
      chk("R8 one bus op", lg_n, 1);

      snoop(3'd2, b, 1'b0, 8'h00, "R10 other tag");
      cpu_op(1'b0, a, 8'h00);
      chk("R10 line kept after other-tag snoop", stall_n, 0);
      snoop(3'd4, a, 1'b0, 8'h00, "R10 snooped write-back");
      cpu_op(1'b0, a, 8'h00);
      chk("R10 line kept after snooped write-back", stall_n, 0);

      snoop(3'd2, a, 1'b0, 8'h00, "R9 write-through-invalidate");
      cpu_op(1'b0, a, 8'h00);
      chk("R9 invalidated line misses", 32'(hit0), 0);
      chk("R9 refetch cmd", 32'(lg_cmd[0]), 1);
      chk("R9 refetch word", 32'(rd), 32'(dv(i, 4)));

      cpu_op(1'b1, b, dv(i, 5));
      chk("R6 write miss flag", 32'(hit0), 0);
      chk("R7 valid victim dropped", lg_n, 1);
      chk("R6 read-invalidate cmd", 32'(lg_cmd[0]), 3);
      chk("R6 read-invalidate addr", 32'(lg_addr[0]), 32'(b));
      cpu_op(1'b0, b, 8'h00);
      chk("R6 dirty line holds word", 32'(rd), 32'(dv(i, 5)));
      chk("R6 read hits", stall_n, 0);
      snoop(3'd3, b, 1'b1, dv(i, 5), "R9 read-invalidate on dirty");
      snoop(3'd1, b, 1'b0, 8'h00, "R10 snoop on invalid line");
      cpu_op(1'b0, b, 8'h00);
      chk("R9 line invalid after read-invalidate", 32'(lg_cmd[0]), 1);
      chk("R9 one bus op", lg_n, 1);

      cpu_op(1'b1, c, dv(i, 6));
      chk("R6 read-invalidate over valid", 32'(lg_cmd[0]), 3);
      cpu_op(1'b0, a, 8'h00);
      chk("R7 two bus ops", lg_n, 2);
      chk("R7 write-back first", 32'(lg_cmd[0]), 4);
      chk("R7 write-back addr", 32'(lg_addr[0]), 32'(c));
      chk("R7 write-back word", 32'(lg_data[0]), 32'(dv(i, 6)));
      chk("R7 fill after write-back", 32'(lg_cmd[1]), 1);
      chk("R7 fill addr", 32'(lg_addr[1]), 32'(a));
      chk("R7 fill word", 32'(rd), 32'(dv(i, 4)));
      chk("R11 stall cycles two ops", stall_n, 5);

      cpu_op(1'b1, a, dv(i, 7));
      chk("R4 write-through to reserve", 32'(lg_cmd[0]), 2);
      cpu_op(1'b0, e, 8'h00);
      chk("R7 reserved victim dropped", lg_n, 1);
      chk("R7 fill of new tag", 32'(lg_cmd[0]), 1);
      chk("R3 fill word new tag", 32'(rd), 32'(init_word(e)));
    end
    summary();
  end

endmodule